// File: doc/BRIEF.md
# Dual-Section Decade Divider

This block counts falling edges on two count-clock inputs inside a single synchronous clock domain. It has a divide-by-two section and a divide-by-five section. Each section has its own count-clock input, and one asynchronous, active-high reset clears both. The count-clock inputs are ordinary data signals. The block samples them on the system clock and finds high-to-low transitions by comparing each sample with the one taken before it.

A two-bit link select chooses how the two sections are joined:

- **Independent:** the sections run on their own inputs.
- **BCD:** the divide-by-two output carries into the divide-by-five section. The four outputs then form an 8-4-2-1 decade.
- **Bi-quinary:** the top bit of the divide-by-five section carries into the divide-by-two section. The divide-by-two output then becomes a square-wave divide-by-ten.

In both cascaded modes the internal carry takes effect in the same system-clock cycle as the edge that caused it.

Top module: `decade_divider`

## Requirements
- R1: A section advances only on the system-clock edge at which its count input is sampled low, provided the sample before it was high. A rising edge or a held level leaves the outputs unchanged, and the new value is visible after that one clock edge.
- R2: While `rst` is high, `q_a`, `q_b`, `q_c` and `q_d` are low and no counting happens. Asserting `rst` clears all four outputs at once, without waiting for a clock edge.
- R3: In independent mode (`link_sel` = 2'b00), each falling edge of `tick_a` inverts `q_a`.
- R4: The divide-by-five section steps {`q_d`,`q_c`,`q_b`} through 0,1,2,3,4 and back to 0, with `q_b` as the least significant bit. In independent mode it advances on falling edges of `tick_b`.
- R5: With `link_sel` = 2'b01 (BCD), falling edges of `tick_a` drive the chain. {`q_d`,`q_c`,`q_b`,`q_a`} counts 0 to 9 in binary and then returns to 0. The divide-by-five section advances in the same cycle that `q_a` goes from 1 to 0.
- R6: With `link_sel` = 2'b10 (bi-quinary), falling edges of `tick_b` drive the chain, and `q_a` inverts in the same cycle that `q_d` falls. The value {`q_a`,`q_d`,`q_c`,`q_b`} therefore runs 0 to 4, then 8 to 12, then repeats. Over any ten input edges, `q_a` is high for five of the resulting states.
- R7: In BCD mode `tick_b` has no effect on any output. In bi-quinary mode `tick_a` has no effect on any output.
- R8: `link_sel` = 2'b11 behaves exactly like independent mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst | input | 1 | Asynchronous active-high reset of both sections |
| tick_a | input | 1 | Count input of the divide-by-two section (falling edge) |
| tick_b | input | 1 | Count input of the divide-by-five section (falling edge) |
| link_sel | input | 2 | 00 independent, 01 BCD, 10 bi-quinary, 11 as 00 |
| q_a | output | 1 | Divide-by-two output |
| q_b | output | 1 | Divide-by-five output, least significant bit |
| q_c | output | 1 | Divide-by-five output, middle bit |
| q_d | output | 1 | Divide-by-five output, most significant bit |

## Verification
The properties assume that the count inputs and `link_sel` change only between system-clock edges, so each one is sampled cleanly. They also assume that a count input stays at each level for at least one whole clock cycle; a shorter pulse could fall between two samples and be lost. The stimulus drives every input change on the falling clock edge and holds each level of a count pulse for a full cycle. It changes `link_sel` only while reset is asserted, so no property sees a count that was started under a different join.

// File: rtl/dec_pkg.sv
package dec_pkg;

    typedef enum logic [1:0] {
        LINK_NONE = 2'b00,
        LINK_BCD  = 2'b01,
        LINK_BIQ  = 2'b10,
        LINK_ALT  = 2'b11
    } link_e;

    localparam int          QUI_W    = 3;
    localparam int          QUI_MOD  = 5;
    localparam logic [2:0]  QUI_LAST = 3'(QUI_MOD - 1);
    localparam int          N_TICKS  = 2;

    typedef struct packed {
        logic adv_two;
        logic adv_five;
    } route_t;

endpackage

// File: rtl/fall_detect.sv
module fall_detect (
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    output logic fall
);
    typedef struct packed {
        logic prev;
    } fd_state_t;

    fd_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = lvl;
        fall      = st_q.prev & ~lvl;
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (rst)
        fall |=> !fall); // R1

endmodule

// File: rtl/toggle_stage.sv
module toggle_stage (
    input  logic clk,
    input  logic rst,
    input  logic adv,
    output logic q
);
    typedef struct packed {
        logic bit_v;
    } tg_state_t;

    tg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (adv) st_d.bit_v = ~st_q.bit_v;
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign q = st_q.bit_v;

    AST_TOGGLE_FLIP: assert property (@(posedge clk) disable iff (rst)
        adv |=> q != $past(q)); // R3
    AST_TOGGLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(q)); // R1

endmodule

// File: rtl/five_stage.sv
module five_stage
    import dec_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    output logic [QUI_W-1:0] cnt,
    output logic             wrap
);
    typedef struct packed {
        logic [QUI_W-1:0] val;
    } fv_state_t;

    fv_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        wrap = adv && (st_q.val == QUI_LAST);
        if (adv) begin
            if (st_q.val == QUI_LAST) st_d.val = '0;
            else                      st_d.val = st_q.val + 1'b1;
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign cnt = st_q.val;

    AST_FIVE_RANGE: assert property (@(posedge clk) disable iff (rst)
        cnt <= QUI_LAST); // R4
    AST_FIVE_STEP: assert property (@(posedge clk) disable iff (rst)
        adv |=> cnt == (($past(cnt) == QUI_LAST) ? '0 : $past(cnt) + 1'b1)); // R4
    AST_FIVE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(cnt)); // R1

endmodule

// File: rtl/decade_divider.sv
module decade_divider
    import dec_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_a,
    input  logic       tick_b,
    input  logic [1:0] link_sel,
    output logic       q_a,
    output logic       q_b,
    output logic       q_c,
    output logic       q_d
);
    logic [N_TICKS-1:0] tick_lvl;
    logic [N_TICKS-1:0] tick_fall;
    logic [QUI_W-1:0]   five_cnt;
    logic               five_wrap;
    logic               two_q;
    route_t             rt_d;

    assign tick_lvl = {tick_b, tick_a};

    for (genvar gi = 0; gi < N_TICKS; gi++) begin : g_edge
        fall_detect u_fall (
            .clk  (clk),
            .rst  (rst),
            .lvl  (tick_lvl[gi]),
            .fall (tick_fall[gi])
        );
    end

    always_comb begin
        rt_d = '0;
        case (link_e'(link_sel))
            LINK_BCD: begin
                rt_d.adv_two  = tick_fall[0];
                rt_d.adv_five = tick_fall[0] & two_q;
            end
            LINK_BIQ: begin
                rt_d.adv_five = tick_fall[1];
                rt_d.adv_two  = five_wrap;
            end
            default: begin
                rt_d.adv_two  = tick_fall[0];
                rt_d.adv_five = tick_fall[1];
            end
        endcase
    end

    toggle_stage u_two (
        .clk (clk),
        .rst (rst),
        .adv (rt_d.adv_two),
        .q   (two_q)
    );

    five_stage u_five (
        .clk  (clk),
        .rst  (rst),
        .adv  (rt_d.adv_five),
        .cnt  (five_cnt),
        .wrap (five_wrap)
    );

    assign q_a = two_q;
    assign q_b = five_cnt[0];
    assign q_c = five_cnt[1];
    assign q_d = five_cnt[2];

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |-> {q_d, q_c, q_b, q_a} == 4'b0000); // R2
    AST_BCD_CARRY: assert property (@(posedge clk) disable iff (rst)
        (link_sel == LINK_BCD && tick_fall[0] && q_a)
        |=> {q_d, q_c, q_b} != $past({q_d, q_c, q_b})); // R5
    AST_BIQ_CARRY: assert property (@(posedge clk) disable iff (rst)
        (link_sel == LINK_BIQ && tick_fall[1] && q_d)
        |=> q_a != $past(q_a)); // R6
    AST_BCD_IGNORE_B: assert property (@(posedge clk) disable iff (rst)
        (link_sel == LINK_BCD && $stable(tick_a))
        |=> $stable({q_d, q_c, q_b, q_a})); // R7
    AST_BIQ_IGNORE_A: assert property (@(posedge clk) disable iff (rst)
        (link_sel == LINK_BIQ && $stable(tick_b))
        |=> $stable({q_d, q_c, q_b, q_a})); // R7

endmodule

// File: tb/decade_divider_test.sv
module decade_divider_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_a = 1'b0;
    logic       tick_b = 1'b0;
    logic [1:0] link_sel = 2'b00;
    logic       q_a, q_b, q_c, q_d;

    always #4 clk = ~clk;

    decade_divider uut (
        .clk      (clk),
        .rst      (rst),
        .tick_a   (tick_a),
        .tick_b   (tick_b),
        .link_sel (link_sel),
        .q_a      (q_a),
        .q_b      (q_b),
        .q_c      (q_c),
        .q_d      (q_d)
    );

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [3:0] val;
        string      req;
    } exp_t;
    exp_t sb[$];

    int m_two  = 0;
    int m_five = 0;

    task automatic chk(string req, logic [3:0] act, logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] model_val();
        return {3'(m_five), 1'(m_two)};
    endfunction

    function automatic void step_five(output bit wrapped);
        wrapped = (m_five == 4);
        m_five  = wrapped ? 0 : m_five + 1;
    endfunction

    function automatic void apply(bit fa, bit fb);
        bit w;
        case (link_sel)
            2'b01: if (fa) begin
                if (m_two == 1) step_five(w);
                m_two ^= 1;
            end
            2'b10: if (fb) begin
                step_five(w);
                if (w) m_two ^= 1;
            end
            default: begin
                if (fa) m_two ^= 1;
                if (fb) step_five(w);
            end
        endcase
    endfunction

    // driver: one count pulse, pushes expectations after the rising half and the falling half
    task automatic pulse(bit fa, bit fb, string req);
        @(negedge clk);
        if (fa) tick_a = 1'b1;
        if (fb) tick_b = 1'b1;
        @(posedge clk);
        sb.push_back('{model_val(), "R1"});
        @(negedge clk);
        tick_a = 1'b0;
        tick_b = 1'b0;
        @(posedge clk);
        apply(fa, fb);
        sb.push_back('{model_val(), req});
    endtask

    task automatic do_reset(logic [1:0] sel);
        @(negedge clk);
        rst = 1'b1;
        link_sel = sel;
        m_two = 0;
        m_five = 0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    // monitor
    initial begin
        forever begin
            @(negedge clk);
            while (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                chk(e.req, {q_d, q_c, q_b, q_a}, e.val);
            end
        end
    end

    initial begin
        #(8 * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int ones;
        repeat (3) @(negedge clk);
        chk("R2", {q_d, q_c, q_b, q_a}, 4'h0);
        rst = 1'b0;

        // independent mode
        for (int i = 0; i < 3; i++) pulse(1, 0, "R3");
        for (int i = 0; i < 7; i++) pulse(0, 1, "R4");
        pulse(1, 1, "R3");

        // level held high for many cycles: no change (R1)
        @(negedge clk);
        tick_b = 1'b1;
        repeat (6) @(negedge clk);
        chk("R1", {q_d, q_c, q_b, q_a}, model_val());
        tick_b = 1'b0;
        @(posedge clk);
        apply(0, 1);
        sb.push_back('{model_val(), "R4"});

        // asynchronous reset in the middle of a count
        @(negedge clk);
        #1 rst = 1'b1;
        #1 chk("R2", {q_d, q_c, q_b, q_a}, 4'h0);
        m_two = 0;
        m_five = 0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); tick_a = 1'b1; tick_b = 1'b1;
            @(negedge clk); tick_a = 1'b0; tick_b = 1'b0;
        end
        @(negedge clk);
        chk("R2", {q_d, q_c, q_b, q_a}, 4'h0);
        rst = 1'b0;

        // BCD
        do_reset(2'b01);
        for (int i = 0; i < 23; i++) pulse(1, 0, "R5");
        for (int i = 0; i < 3; i++) pulse(0, 1, "R7");

        // bi-quinary
        do_reset(2'b10);
        for (int i = 0; i < 25; i++) pulse(0, 1, "R6");
        ones = 0;
        for (int i = 0; i < 10; i++) begin
            pulse(0, 1, "R6");
            @(negedge clk);
            ones += int'(q_a);
        end
        checks++;
        if (ones != 5) begin
            errors++;
            $display("FAIL R6 actual=%0d expected=5 high states", ones);
        end
        for (int i = 0; i < 3; i++) pulse(1, 0, "R7");

        // 2'b11 acts as independent
        do_reset(2'b11);
        for (int i = 0; i < 3; i++) pulse(1, 0, "R8");
        for (int i = 0; i < 6; i++) pulse(0, 1, "R8");
        pulse(1, 1, "R8");

        repeat (3) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule